// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a single-port synchronous SRAM with one shared data path per word, built from four 9-bit byte lanes and a parameterised address width. Every control and data input is taken on the rising clock edge. A read word passes through an output register, and a separate enable output tells the pad ring when to drive the shared data bus. That enable follows an asynchronous, active-low output enable.

Accesses start on one of two address strobes. The processor strobe always opens with a read, and its write data can only follow on the next edge. The controller strobe can write in the same edge that opens the access. After an access opens, a two-bit burst counter steps the two low address bits in linear or interleaved order when advance is low, and holds them when advance is high. Byte masking lets a write touch any subset of the four lanes. A global write stores the whole word.

Top module: `sync_burst_sram`

## Requirements
- R1: An access opens only on an edge where a strobe is honoured and all three chip selects are active (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0). On an edge with no strobe, the `addr` input is ignored.
- R2: When both strobes are low, only the processor strobe counts, so write controls on that edge store nothing. The processor strobe is ignored when `sel_a_n` is high, and in that case a low controller strobe with inactive selects deselects the device.
- R3: A processor-strobe access reads in its opening edge and ignores write controls there. Write controls on the next strobe-free edge (advance high) write the data then present to the same address.
- R4: A controller-strobe edge whose write controls are active (processor strobe high) writes `wdata` to `addr` on that same edge.
- R5: `wr_all_n`=0 writes all four lanes. Otherwise lane i (bits 9i+8..9i) is written only when `wr_byte_n`=0 and `lane_n[i]`=0, and unwritten lanes keep their contents.
- R6: Read data for an address opened at edge k is on `rdata` after edge k+1. `rdata_oe` is high only while `oe_n` is low, and it follows `oe_n` without waiting for a clock.
- R7: When an access opens from the deselected state, `rdata_oe` stays low for the cycle after the opening edge, whatever `oe_n` is.
- R8: An edge that writes drives `rdata_oe` low after it. The bus stays undriven until a strobe or an advance read occurs.
- R9: A strobed edge with the chip selects inactive drives `rdata_oe` low right after that edge.
- R10: With `burst_linear`=1, the low address bits advance as first, first+1, first+2, first+3 (mod 4). For example, first 1 gives 1,2,3,0.
- R11: With `burst_linear`=0, the low bits follow first XOR step for step 0..3. For example, first 1 gives 1,0,3,2.
- R12: A strobe-free edge with advance high keeps the current address, and the read word stays valid on the bus.
- R13: During and after synchronous reset, with no access opened, `rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, low two bits seed the burst counter |
| sel_a_n | input | 1 | Chip select A, active low, also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write select, active low |
| burst_linear | input | 1 | Static burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Output register contents |
| rdata_oe | output | 1 | Drive enable for the shared data bus |

## Verification
A read opened at edge k gives its word one edge later, at k+1. A write lands in memory on the edge that carries it. The effect of strobes, deselects and writes on the bus enable shows right after the edge where they are sampled, and an asynchronous output-enable change shows with no edge at all. The bench drives every input 2 ns after a rising edge and samples at the same offset after each following edge, so each check reads a known edge count. Burst checks then compare one word per edge against an order computed in the bench. Read-back checks use a model of memory kept in the bench from the writes it has issued.

// File: rtl/sram_pkg.sv
package sram_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_DESEL = 2'd1,
        CYC_START = 2'd2,
        CYC_CONT  = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e kind;
        logic      by_ctl;
        logic      adv;
    } cyc_dec_s;

    function automatic logic [1:0] burst_low(input logic lin,
                                             input logic [1:0] first,
                                             input logic [1:0] step);
        logic [1:0] r;
        r = lin ? (first + step) : (first ^ step);
        return r;
    endfunction

endpackage

// File: rtl/sram_lane_decode.sv
module sram_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_we,
    output logic             wr_req
);
    always_comb begin
        if (!wr_all_n)
            lane_we = '1;
        else if (!wr_byte_n)
            lane_we = ~lane_n;
        else
            lane_we = '0;
    end

    assign wr_req = |lane_we;
endmodule

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr
    import sram_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       adv,
    input  logic       linear,
    input  logic [1:0] first_in,
    output logic [1:0] cur_low,
    output logic [1:0] next_low
);
    logic [1:0] first_q;
    logic [1:0] step_q;
    logic [1:0] step_nx;

    assign step_nx = step_q + 2'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            step_q  <= '0;
        end else if (load) begin
            first_q <= first_in;
            step_q  <= '0;
        end else if (adv) begin
            step_q  <= step_nx;
        end
    end

    assign cur_low  = burst_low(linear, first_q, step_q);
    assign next_low = burst_low(linear, first_q, step_nx);
endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we[g])
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            if (rd_en)
                rd_q <= mem[rd_addr];
        end

        assign rd_data[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    strb_cpu_n,
    input  logic                    strb_ctl_n,
    input  logic                    adv_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    burst_linear,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);
    localparam int WORD_W = LANES * LANE_W;
    localparam int HI_W   = ADDR_W - 2;

    logic            sel_ok, cpu_go, ctl_go;
    cyc_dec_s        dec;
    logic [LANES-1:0] lane_we, arr_we;
    logic            wr_req, wr_fire, rd_en;
    logic [1:0]      cur_low, next_low;
    logic [HI_W-1:0] base_hi;
    logic            active, rd_pend, out_vld;
    logic [ADDR_W-1:0] wr_addr, rd_addr;

    // strobe qualification and cycle classification
    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;
    assign cpu_go = !strb_cpu_n && !sel_a_n;
    assign ctl_go = !strb_ctl_n && !cpu_go;

    always_comb begin
        dec.by_ctl = ctl_go;
        dec.adv    = !adv_n;
        if (cpu_go || ctl_go)
            dec.kind = sel_ok ? CYC_START : CYC_DESEL;
        else
            dec.kind = active ? CYC_CONT : CYC_IDLE;
    end

    sram_lane_decode #(.LANES(LANES)) u_dec (
        .wr_all_n (wr_all_n),
        .wr_byte_n(wr_byte_n),
        .lane_n   (lane_n),
        .lane_we  (lane_we),
        .wr_req   (wr_req)
    );

    sram_burst_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load    (dec.kind == CYC_START),
        .adv     (dec.kind == CYC_CONT && dec.adv),
        .linear  (burst_linear),
        .first_in(addr[1:0]),
        .cur_low (cur_low),
        .next_low(next_low)
    );

    // a processor-strobe opening edge never writes
    assign wr_fire = wr_req && ((dec.kind == CYC_START && dec.by_ctl) ||
                                 dec.kind == CYC_CONT);
    assign arr_we  = wr_fire ? lane_we : '0;
    assign wr_addr = (dec.kind == CYC_START) ? addr
                   : {base_hi, (dec.adv ? next_low : cur_low)};
    assign rd_addr = {base_hi, cur_low};
    assign rd_en   = rd_pend && !wr_fire &&
                     (dec.kind == CYC_START || dec.kind == CYC_CONT);

    sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk    (clk),
        .we     (arr_we),
        .wr_addr(wr_addr),
        .wr_data(wdata),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_data(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            base_hi <= '0;
            rd_pend <= 1'b0;
            out_vld <= 1'b0;
        end else begin
            case (dec.kind)
                CYC_START: begin
                    active  <= 1'b1;
                    base_hi <= addr[ADDR_W-1:2];
                    rd_pend <= !wr_fire;
                    out_vld <= wr_fire ? 1'b0 : rd_pend;
                end
                CYC_CONT: begin
                    if (wr_fire) begin
                        rd_pend <= 1'b0;
                        out_vld <= 1'b0;
                    end else begin
                        rd_pend <= rd_pend || dec.adv;
                        out_vld <= rd_pend;
                    end
                end
                default: begin
                    if (dec.kind == CYC_DESEL) active <= 1'b0;
                    rd_pend <= 1'b0;
                    out_vld <= 1'b0;
                end
            endcase
        end
    end

    assign rdata_oe = out_vld && !oe_n;

    // checks next to the control path
    AST_OE_GATE: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> !oe_n);                                         // R6
    AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (rst)
        (((!strb_cpu_n && !sel_a_n) || !strb_ctl_n) &&
         !(!sel_a_n && sel_b && !sel_c_n)) |=> !rdata_oe);           // R9
    AST_WR_HIZ: assert property (@(posedge clk) disable iff (rst)
        (!strb_ctl_n && strb_cpu_n && !sel_a_n && sel_b && !sel_c_n &&
         !wr_all_n) |=> !rdata_oe);                                  // R8
    AST_FIRST_HIZ: assert property (@(posedge clk) disable iff (rst)
        (!active && dec.kind == CYC_START) |=> !rdata_oe);           // R7
    AST_CPU_NOWR: assert property (@(posedge clk) disable iff (rst)
        (!strb_cpu_n && !sel_a_n && sel_b && !sel_c_n) |-> arr_we == '0); // R3
endmodule

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
    localparam int AW = 8;
    localparam int W  = 36;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          sel_a_n, sel_b, sel_c_n;
    logic          strb_cpu_n, strb_ctl_n, adv_n;
    logic          wr_all_n, wr_byte_n;
    logic [3:0]    lane_n;
    logic          burst_linear, oe_n;
    logic [W-1:0]  wdata, rdata;
    logic          rdata_oe;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] ref_m [256];

    always #4 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .adv_n(adv_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
        .lane_n(lane_n), .burst_linear(burst_linear), .oe_n(oe_n),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic idle_in;
        sel_a_n = 0; sel_b = 1; sel_c_n = 0;
        strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
        wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF; oe_n = 0;
    endtask

    task automatic ref_write(input logic [AW-1:0] a, input logic [W-1:0] d,
                             input logic gw, input logic bw, input logic [3:0] ln);
        for (int i = 0; i < 4; i++)
            if (!gw || (!bw && !ln[i])) ref_m[a][i*9 +: 9] = d[i*9 +: 9];
    endtask

    task automatic ctl_write(input logic [AW-1:0] a, input logic [W-1:0] d,
                             input logic gw, input logic bw, input logic [3:0] ln);
        idle_in();
        strb_ctl_n = 0; addr = a; wdata = d;
        wr_all_n = gw; wr_byte_n = bw; lane_n = ln;
        tick();
        ref_write(a, d, gw, bw, ln);
        idle_in();
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input string tag);
        idle_in();
        strb_ctl_n = 0; addr = a;
        tick();
        idle_in();
        tick();
        chk(rdata_oe === 1'b1, tag, {35'd0, rdata_oe}, 36'd1);
        chk(rdata === ref_m[a], tag, rdata, ref_m[a]);
    endtask

    task automatic t_reset;
        idle_in(); addr = 0; wdata = 0; burst_linear = 1; rst = 1;
        tick(); tick();
        chk(rdata_oe === 1'b0, "R13 in reset", {35'd0, rdata_oe}, 36'd0);
        rst = 0;
        tick();
        chk(rdata_oe === 1'b0, "R13 after reset", {35'd0, rdata_oe}, 36'd0);
    endtask

    task automatic t_ctl_write_read;
        ctl_write(8'h05, 36'h9_1234_5678, 0, 1, 4'hF);
        read_chk(8'h05, "R4 R6 same-edge write readback");
        oe_n = 1; #1;
        chk(rdata_oe === 1'b0, "R6 oe_n high undriven", {35'd0, rdata_oe}, 36'd0);
        oe_n = 0; #1;
        chk(rdata_oe === 1'b1, "R6 oe_n low driven", {35'd0, rdata_oe}, 36'd1);
        // R1: address change without strobe has no effect during suspend
        ctl_write(8'h06, 36'h1_1111_1111, 0, 1, 4'hF);
        read_chk(8'h05, "R1 setup");
        addr = 8'h06; tick();
        chk(rdata === ref_m[8'h05], "R1 addr ignored w/o strobe", rdata, ref_m[8'h05]);
    endtask

    task automatic t_bytes;
        ctl_write(8'h50, 36'h0, 0, 1, 4'hF);
        ctl_write(8'h50, 36'hF_FFFF_FFFF, 1, 0, 4'b1010);
        read_chk(8'h50, "R5 lanes 0 and 2");
        ctl_write(8'h50, 36'hA_AAAA_AAAA, 1, 1, 4'h0);
        read_chk(8'h50, "R5 byte enable off no write");
        ctl_write(8'h50, 36'h5_5555_5555, 0, 1, 4'hF);
        read_chk(8'h50, "R5 global write all lanes");
    endtask

    task automatic t_strobes;
        ctl_write(8'h40, 36'h4_0404_0404, 0, 1, 4'hF);
        ctl_write(8'h41, 36'h4_1414_1414, 0, 1, 4'hF);
        // both strobes low with write controls: treated as processor read
        idle_in();
        strb_cpu_n = 0; strb_ctl_n = 0; addr = 8'h40;
        wr_all_n = 0; wdata = 36'hB_BBBB_BBBB;
        tick();
        idle_in(); tick();
        chk(rdata === ref_m[8'h40], "R2 both strobes no write", rdata, ref_m[8'h40]);
        read_chk(8'h40, "R2 memory unchanged");
        // processor strobe then write on the next edge
        idle_in();
        strb_cpu_n = 0; addr = 8'h41; wr_all_n = 0; wdata = 36'hC_CCCC_CCCC;
        tick();
        strb_cpu_n = 1; wdata = 36'hD_DDDD_DDDD;
        tick();
        ref_m[8'h41] = 36'hD_DDDD_DDDD;
        idle_in();
        read_chk(8'h41, "R3 two-cycle processor write");
        // processor strobe ignored while sel_a_n high; controller deselects
        idle_in();
        strb_cpu_n = 0; strb_ctl_n = 0; sel_a_n = 1; addr = 8'h41;
        tick();
        chk(rdata_oe === 1'b0, "R2 cpu ignored, ctl deselects", {35'd0, rdata_oe}, 36'd0);
        idle_in();
    endtask

    task automatic t_desel;
        read_chk(8'h40, "R9 setup");
        strb_ctl_n = 0; sel_b = 0;
        tick();
        chk(rdata_oe === 1'b0, "R9 deselect undriven", {35'd0, rdata_oe}, 36'd0);
        idle_in(); tick();
        chk(rdata_oe === 1'b0, "R9 stays undriven", {35'd0, rdata_oe}, 36'd0);
        strb_ctl_n = 0; addr = 8'h41;
        tick();
        chk(rdata_oe === 1'b0, "R7 first cycle masked", {35'd0, rdata_oe}, 36'd0);
        idle_in(); tick();
        chk(rdata_oe === 1'b1 && rdata === ref_m[8'h41], "R7 then driven",
            rdata, ref_m[8'h41]);
    endtask

    task automatic t_write_hiz;
        ctl_write(8'h30, 36'h3_0303_0303, 0, 1, 4'hF);
        ctl_write(8'h31, 36'h3_1313_1313, 0, 1, 4'hF);
        read_chk(8'h30, "R8 setup");
        wr_all_n = 0; wdata = 36'hE_EEEE_EEEE;
        tick();
        ref_m[8'h30] = 36'hE_EEEE_EEEE;
        chk(rdata_oe === 1'b0, "R8 write undriven", {35'd0, rdata_oe}, 36'd0);
        idle_in(); tick();
        chk(rdata_oe === 1'b0, "R8 suspend after write undriven", {35'd0, rdata_oe}, 36'd0);
        adv_n = 0; tick();
        adv_n = 1; tick();
        chk(rdata_oe === 1'b1 && rdata === ref_m[8'h31], "R8 advance read driven",
            rdata, ref_m[8'h31]);
        read_chk(8'h30, "R8 continue write stored");
    endtask

    task automatic t_burst(input logic lin, input string tag);
        logic [1:0] first;
        logic [AW-1:0] a;
        first = 2'd1;
        burst_linear = lin;
        for (int i = 0; i < 4; i++)
            ctl_write(8'h20 + AW'(i), 36'hA_0000_0A00 + W'(i) + (lin ? 36'h100 : 36'h0), 0, 1, 4'hF);
        idle_in();
        strb_ctl_n = 0; addr = 8'h21;
        tick();
        idle_in(); adv_n = 0;
        for (int s = 0; s < 4; s++) begin
            if (s == 3) adv_n = 1;
            tick();
            a = {6'h08, (lin ? 2'(first + 2'(s)) : (first ^ 2'(s)))};
            chk(rdata_oe === 1'b1 && rdata === ref_m[a], tag, rdata, ref_m[a]);
        end
        tick();
        chk(rdata === ref_m[a], "R12 suspend holds word", rdata, ref_m[a]);
        idle_in();
    endtask

    initial begin
        t_reset();
        t_ctl_write_read();
        t_bytes();
        t_strobes();
        t_desel();
        t_write_hiz();
        t_burst(1'b1, "R10 linear order");
        t_burst(1'b0, "R11 interleaved order");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 36'd0, 36'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule